// File: doc/BRIEF.md
# Depth Layer Peeling Unit

This block settles visibility for one group of 32 pixels in a screen tile. It does this over several peel passes instead of one depth-buffer pass. In each pass a stream of fragments arrives. Every fragment carries a pixel index, an unsigned floating-point depth and a 29-bit primitive tag. Each pixel keeps a working depth and tag for the current pass, and a reference depth taken from the pass before. A fragment only counts if it lies strictly beyond that reference in the current peel direction.

The peel direction is chosen when the tile starts. Front-to-back peeling serves alpha-tested (punch-through) geometry: each pass keeps the nearest fragment behind the previous layer. Back-to-front peeling serves blended (translucent) geometry: each pass keeps the farthest fragment in front of the previous layer.

When a pass ends, the block sends out the result of every pixel in turn. It then waits for a feedback mask that names the pixels whose shaded fragment failed the alpha test. Only those pixels take part in the next peel. Every other pixel is frozen. A done flag rises once no pixel remains in play.

Top module: `peel_span_unit`

## Requirements
- R1: Incoming depth is 31 bits (8 exponent and 23 mantissa bits, no sign). The low 4 bits are dropped, and the remaining 27 bits, `frag_depth[30:4]`, are stored, compared as unsigned integers and reported on `out_depth`.
- R2: With `mode_in`=0 latched at tile start (front-to-back), the first pass of a tile keeps the fragment with the smallest stored depth for each pixel. On equal stored depth the earlier fragment stays. `out_tag` reports the tag of the kept fragment.
- R3: In front-to-back mode, after a pixel has been peeled, a fragment qualifies only if its stored depth is strictly greater than the pixel's reference depth. The reference depth is the depth kept in the previous pass.
- R4: With `mode_in`=1 latched at tile start (back-to-front), each pass keeps the largest stored depth. After a peel, a fragment qualifies only if it is strictly smaller than the reference depth. On equal depth the earlier fragment stays.
- R5: A pixel that gets no qualifying fragment in a pass reports `out_hit`=0. It also reports the background tag on `out_tag`, and its reset depth on `out_depth`: all ones front-to-back, zero back-to-front.
- R6: In the clock after `pass_end` is sampled, `out_valid` stays high for 32 consecutive cycles with `out_pix` counting 0 to 31. `frag_ready` is low from that cycle until feedback is taken.
- R7: A fragment accepted in the same cycle as `pass_end` belongs to the pass that is ending.
- R8: Feedback (`fb_valid` while waiting) peels a pixel again only if its `fb_mask` bit is set and it was active and hit in the pass. All other pixels are frozen: they ignore fragments, report `out_hit`=0 and keep their last depth and tag.
- R9: `done` is high after reset and whenever no pixel is active. It goes low after `tile_start`.
- R10: `out_stencil` (2 bits per pixel) is cleared by `tile_start` and stays unchanged through all passes.
- R11: `mode_in` is sampled only in the `tile_start` cycle. 0 selects front-to-back and 1 selects back-to-front for the whole tile.
- R12: `bg_load` writes `bg_tag_in` into the background tag register. Both tile start and each new peel reset active pixels' tags to that register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 1 | Peel direction, taken at tile start (0 front-to-back, 1 back-to-front) |
| bg_load | input | 1 | Write strobe for the background tag register |
| bg_tag_in | input | 29 | Background tag value |
| tile_start | input | 1 | Clears all pixel state and begins the first pass |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Block accepts fragments (collecting phase) |
| frag_pix | input | 5 | Pixel index 0..31 |
| frag_depth | input | 31 | Unsigned float depth |
| frag_tag | input | 29 | Primitive tag |
| pass_end | input | 1 | Closes the current pass and starts result output |
| out_valid | output | 1 | Result output valid |
| out_pix | output | 5 | Pixel index of the result |
| out_hit | output | 1 | Pixel took a qualifying fragment this pass |
| out_depth | output | 27 | Stored working depth |
| out_tag | output | 29 | Stored winning tag |
| out_stencil | output | 2 | Stencil bits of the pixel |
| fb_valid | input | 1 | Feedback mask present |
| fb_mask | input | 32 | Pixels whose fragment failed the alpha test |
| done | output | 1 | No pixel left to peel |

## Verification
A fragment can land in the same cycle as `pass_end`, so the block must take one more depth update while it starts closing the pass. The bench provokes this by sending the last fragment of a pass, for pixel 31, with the `pass_end` strobe. It then checks that this fragment, not an earlier farther one, is the one pixel 31 reports. The second overlap is a fragment aimed at a frozen pixel during a later peel. The bench shows that this fragment leaves the pixel's reported depth, tag and hit flag untouched, while an active neighbour in the same stream still updates.

// File: rtl/peel_pkg.sv
package peel_pkg;
   typedef enum logic {
      DIR_FRONT = 1'b0,
      DIR_BACK  = 1'b1
   } peel_dir_e;

   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_EMIT    = 2'd1,
      ST_AWAIT   = 2'd2
   } peel_state_e;
endpackage

// File: rtl/peel_seq_ctrl.sv
module peel_seq_ctrl import peel_pkg::*; #(
   parameter int PIXELS = 32,
   localparam int PIX_W = $clog2(PIXELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tile_start,
   input  logic             pass_end,
   input  logic             fb_valid,
   output logic             collect,
   output logic             emitting,
   output logic [PIX_W-1:0] emit_idx,
   output logic             fb_take
);
   localparam logic [PIX_W-1:0] LAST_IDX = PIX_W'(PIXELS - 1);

   peel_state_e state_q;

   assign collect  = (state_q == ST_COLLECT);
   assign emitting = (state_q == ST_EMIT);
   assign fb_take  = (state_q == ST_AWAIT) && fb_valid && !tile_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_COLLECT;
         emit_idx <= '0;
      end else if (tile_start) begin
         state_q  <= ST_COLLECT;
         emit_idx <= '0;
      end else begin
         unique case (state_q)
            ST_COLLECT: if (pass_end) begin
               state_q  <= ST_EMIT;
               emit_idx <= '0;
            end
            ST_EMIT: if (emit_idx == LAST_IDX) state_q <= ST_AWAIT;
                     else emit_idx <= emit_idx + 1'b1;
            ST_AWAIT: if (fb_valid) state_q <= ST_COLLECT;
            default: state_q <= ST_COLLECT;
         endcase
      end
   end

   assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      collect && pass_end && !tile_start |=> !collect && emitting);
endmodule

// File: rtl/peel_pixel_cell.sv
module peel_pixel_cell import peel_pkg::*; #(
   parameter int DEPTH_W   = 27,
   parameter int TAG_W     = 29,
   parameter int STENCIL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tile_start,
   input  peel_dir_e            dir,
   input  logic [TAG_W-1:0]     bg_tag,
   input  logic                 wr_en,
   input  logic [DEPTH_W-1:0]   wr_depth,
   input  logic [TAG_W-1:0]     wr_tag,
   input  logic                 fb_take,
   input  logic                 fb_flag,
   output logic                 active,
   output logic                 hit,
   output logic [DEPTH_W-1:0]   depth,
   output logic [TAG_W-1:0]     tag,
   output logic [STENCIL_W-1:0] stencil
);
   logic               has_ref;
   logic [DEPTH_W-1:0] ref_depth;
   logic [DEPTH_W-1:0] limit;
   logic               past_ref, nearer_pick, qualifies;

   assign limit       = (dir == DIR_BACK) ? '0 : '1;
   assign past_ref    = (dir == DIR_BACK) ? (wr_depth < ref_depth) : (wr_depth > ref_depth);
   assign nearer_pick = (dir == DIR_BACK) ? (wr_depth > depth) : (wr_depth < depth);
   assign qualifies   = (!has_ref || past_ref) && (!hit || nearer_pick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         has_ref   <= 1'b0;
         hit       <= 1'b0;
         depth     <= '1;
         ref_depth <= '0;
         tag       <= '0;
         stencil   <= '0;
      end else if (tile_start) begin
         active    <= 1'b1;
         has_ref   <= 1'b0;
         hit       <= 1'b0;
         depth     <= limit;
         ref_depth <= '0;
         tag       <= bg_tag;
         stencil   <= '0;
      end else if (fb_take) begin
         hit <= 1'b0;
         if (active && hit && fb_flag) begin
            ref_depth <= depth;
            has_ref   <= 1'b1;
            depth     <= limit;
            tag       <= bg_tag;
         end else begin
            active <= 1'b0;
         end
      end else if (wr_en && active && qualifies) begin
         depth <= wr_depth;
         tag   <= wr_tag;
         hit   <= 1'b1;
      end
   end

   assert_hit_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> active);
   assert_front_beyond_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && has_ref && !tile_start && dir == DIR_FRONT |-> depth > ref_depth);
   assert_back_before_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit && has_ref && !tile_start && dir == DIR_BACK |-> depth < ref_depth);
   assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !active && !tile_start |=> $stable(depth) && $stable(tag) && !hit);
endmodule

// File: rtl/peel_span_unit.sv
module peel_span_unit import peel_pkg::*; #(
   parameter int PIXELS     = 32,
   parameter int IN_DEPTH_W = 31,
   parameter int DROP_BITS  = 4,
   parameter int TAG_W      = 29,
   parameter int STENCIL_W  = 2,
   localparam int PIX_W     = $clog2(PIXELS),
   localparam int DEPTH_W   = IN_DEPTH_W - DROP_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_in,
   input  logic                  bg_load,
   input  logic [TAG_W-1:0]      bg_tag_in,
   input  logic                  tile_start,
   input  logic                  frag_valid,
   output logic                  frag_ready,
   input  logic [PIX_W-1:0]      frag_pix,
   input  logic [IN_DEPTH_W-1:0] frag_depth,
   input  logic [TAG_W-1:0]      frag_tag,
   input  logic                  pass_end,
   output logic                  out_valid,
   output logic [PIX_W-1:0]      out_pix,
   output logic                  out_hit,
   output logic [DEPTH_W-1:0]    out_depth,
   output logic [TAG_W-1:0]      out_tag,
   output logic [STENCIL_W-1:0]  out_stencil,
   input  logic                  fb_valid,
   input  logic [PIXELS-1:0]     fb_mask,
   output logic                  done
);
   if (PIXELS < 2 || (PIXELS & (PIXELS - 1)) != 0) begin : g_bad_pixels
      $error("PIXELS must be a power of two of at least 2");
   end
   if (DROP_BITS < 1 || DROP_BITS >= IN_DEPTH_W) begin : g_bad_drop
      $error("DROP_BITS must lie between 1 and IN_DEPTH_W-1");
   end
   if (TAG_W < 1 || STENCIL_W < 1) begin : g_bad_widths
      $error("TAG_W and STENCIL_W must be positive");
   end

   localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(PIXELS - 1);

   logic [TAG_W-1:0]   bg_q;
   peel_dir_e          dir_q, dir_now;
   logic               collect, emitting, fb_take, frag_take;
   logic [PIX_W-1:0]   emit_idx;
   logic [DEPTH_W-1:0] trunc_depth;
   logic               unused_low_bits;
   logic [PIXELS-1:0]  active_vec, hit_vec;
   logic [DEPTH_W-1:0] depth_a   [PIXELS];
   logic [TAG_W-1:0]   tag_a     [PIXELS];
   logic [STENCIL_W-1:0] sten_a  [PIXELS];

   assign trunc_depth     = frag_depth[IN_DEPTH_W-1:DROP_BITS];
   assign unused_low_bits = ^frag_depth[DROP_BITS-1:0];
   assign dir_now         = tile_start ? peel_dir_e'(mode_in) : dir_q;
   assign frag_take       = frag_valid && collect && !tile_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bg_q  <= '0;
         dir_q <= DIR_FRONT;
      end else begin
         if (bg_load)    bg_q  <= bg_tag_in;
         if (tile_start) dir_q <= peel_dir_e'(mode_in);
      end
   end

   peel_seq_ctrl #(.PIXELS(PIXELS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tile_start(tile_start), .pass_end(pass_end),
      .fb_valid(fb_valid), .collect(collect), .emitting(emitting),
      .emit_idx(emit_idx), .fb_take(fb_take)
   );

   for (genvar g = 0; g < PIXELS; g++) begin : g_pix
      logic wr_here;
      assign wr_here = frag_take && (frag_pix == PIX_W'(g));
      peel_pixel_cell #(.DEPTH_W(DEPTH_W), .TAG_W(TAG_W), .STENCIL_W(STENCIL_W)) u_cell (
         .clk(clk), .rst_n(rst_n), .tile_start(tile_start), .dir(dir_now),
         .bg_tag(bg_q), .wr_en(wr_here), .wr_depth(trunc_depth), .wr_tag(frag_tag),
         .fb_take(fb_take), .fb_flag(fb_mask[g]),
         .active(active_vec[g]), .hit(hit_vec[g]), .depth(depth_a[g]),
         .tag(tag_a[g]), .stencil(sten_a[g])
      );
   end

   assign frag_ready  = collect;
   assign done        = ~|active_vec;
   assign out_valid   = emitting;
   assign out_pix     = emit_idx;
   assign out_hit     = hit_vec[emit_idx];
   assign out_depth   = depth_a[emit_idx];
   assign out_tag     = tag_a[emit_idx];
   assign out_stencil = sten_a[emit_idx];

   assert_pix_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_pix != LAST_PIX && !tile_start |=>
         out_valid && out_pix == PIX_W'($past(out_pix) + 1'b1));
   assert_emit_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_pix == LAST_PIX && !tile_start |=> !out_valid && !frag_ready);
   assert_empty_feedback_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fb_valid && !frag_ready && !out_valid && !tile_start && fb_mask == '0 |=> done);
   assert_tile_start_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tile_start |=> !done && frag_ready);
endmodule

// File: tb/peel_span_unit_tb_top.sv
module peel_span_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NPIX = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mode_in = 1'b0, bg_load = 1'b0, tile_start = 1'b0;
   logic [28:0] bg_tag_in = '0;
   logic frag_valid = 1'b0, pass_end = 1'b0, fb_valid = 1'b0;
   logic [4:0] frag_pix = '0;
   logic [30:0] frag_depth = '0;
   logic [28:0] frag_tag = '0;
   logic [31:0] fb_mask = '0;
   logic frag_ready, out_valid, out_hit, done;
   logic [4:0] out_pix;
   logic [26:0] out_depth;
   logic [28:0] out_tag;
   logic [1:0] out_stencil;

   int total = 0, bad = 0, cycles = 0;
   bit chk_en = 0;

   // behavioural reference state
   bit m_act[NPIX], m_hit[NPIX], m_href[NPIX];
   int unsigned m_ref[NPIX], m_work[NPIX], m_tag[NPIX];
   bit m_back = 0, m_ready = 1;
   int unsigned m_bg = 0;
   bit cap_hit[NPIX];
   int unsigned cap_tag[NPIX], cap_depth[NPIX];

   peel_span_unit dut_i (
      .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .bg_load(bg_load),
      .bg_tag_in(bg_tag_in), .tile_start(tile_start), .frag_valid(frag_valid),
      .frag_ready(frag_ready), .frag_pix(frag_pix), .frag_depth(frag_depth),
      .frag_tag(frag_tag), .pass_end(pass_end), .out_valid(out_valid),
      .out_pix(out_pix), .out_hit(out_hit), .out_depth(out_depth),
      .out_tag(out_tag), .out_stencil(out_stencil), .fb_valid(fb_valid),
      .fb_mask(fb_mask), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit m_done();
      for (int i = 0; i < NPIX; i++) if (m_act[i]) return 0;
      return 1;
   endfunction

   always @(negedge clk) begin
      if (chk_en) begin
         chk(frag_ready == m_ready, "R6 frag_ready", frag_ready, m_ready);
         chk(done == m_done(), "R9 done", done, m_done());
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         chk(0, "watchdog", cycles, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic void model_frag(int p, int unsigned d, int unsigned t);
      int unsigned q = d >> 4;
      bit ok;
      if (!m_act[p]) return;
      if (!m_back) ok = (!m_href[p] || q > m_ref[p]) && (!m_hit[p] || q < m_work[p]);
      else         ok = (!m_href[p] || q < m_ref[p]) && (!m_hit[p] || q > m_work[p]);
      if (ok) begin m_work[p] = q; m_tag[p] = t; m_hit[p] = 1; end
   endfunction

   task automatic load_bg(input int unsigned v);
      @(negedge clk); bg_load = 1; bg_tag_in = v[28:0];
      @(posedge clk); m_bg = v & 32'h1FFF_FFFF;
      @(negedge clk); bg_load = 0;
   endtask

   task automatic start_tile(input bit back);
      @(negedge clk); tile_start = 1; mode_in = back;
      @(posedge clk);
      m_back = back; m_ready = 1;
      for (int i = 0; i < NPIX; i++) begin
         m_act[i] = 1; m_hit[i] = 0; m_href[i] = 0; m_ref[i] = 0;
         m_work[i] = back ? 0 : 32'h07FF_FFFF; m_tag[i] = m_bg;
      end
      @(negedge clk); tile_start = 0; mode_in = ~back;  // later mode changes must not matter (R11)
   endtask

   task automatic send(input int p, input int unsigned d, input int unsigned t);
      @(negedge clk); frag_valid = 1; frag_pix = p[4:0]; frag_depth = d[30:0]; frag_tag = t[28:0];
      @(posedge clk); model_frag(p, d, t);
   endtask

   task automatic close_pass(input bit with_frag, input int p, input int unsigned d, input int unsigned t);
      @(negedge clk); pass_end = 1; frag_valid = with_frag;
      frag_pix = p[4:0]; frag_depth = d[30:0]; frag_tag = t[28:0];
      @(posedge clk); if (with_frag) model_frag(p, d, t); m_ready = 0;
      @(negedge clk); pass_end = 0; frag_valid = 0;
      for (int k = 0; k < NPIX; k++) begin
         chk(out_valid && out_pix == k[4:0], "R6 emit order", out_pix, k);
         chk(out_hit == m_hit[k], "R8 hit flag", out_hit, m_hit[k]);
         chk(out_depth == m_work[k][26:0], "R1 depth", out_depth, m_work[k]);
         chk(out_tag == m_tag[k][28:0], "R2 tag", out_tag, m_tag[k]);
         chk(out_stencil == 2'b00, "R10 stencil", out_stencil, 0);
         cap_hit[k] = out_hit; cap_tag[k] = out_tag; cap_depth[k] = out_depth;
         @(negedge clk);
      end
      chk(!out_valid, "R6 emit end", out_valid, 0);
   endtask

   task automatic feedback(input logic [31:0] mask);
      fb_valid = 1; fb_mask = mask;
      @(posedge clk);
      for (int i = 0; i < NPIX; i++) begin
         if (m_act[i] && m_hit[i] && mask[i]) begin
            m_ref[i] = m_work[i]; m_href[i] = 1;
            m_work[i] = m_back ? 0 : 32'h07FF_FFFF; m_tag[i] = m_bg;
         end else m_act[i] = 0;
         m_hit[i] = 0;
      end
      m_ready = 1;
      @(negedge clk); fb_valid = 0; fb_mask = '0;
   endtask

   initial begin
      for (int i = 0; i < NPIX; i++) begin
         m_act[i] = 0; m_hit[i] = 0; m_href[i] = 0; m_ref[i] = 0; m_work[i] = 0; m_tag[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1; chk_en = 1;
      @(negedge clk);
      chk(done == 1, "R9 reset done", done, 1);
      chk(out_valid == 0, "R6 reset out_valid", out_valid, 0);

      // tile 1: front-to-back
      load_bg(32'h0ABC_DEF0);
      start_tile(0);
      chk(done == 0, "R9 live after tile start", done, 0);
      send(0, 'h500, 10); send(0, 'h300, 11); send(0, 'h400, 12);
      send(2, 'h10F, 20); send(2, 'h100, 21);
      send(3, 'h800, 30);
      send(4, 'h200, 40); send(4, 'h200, 41);
      send(31, 'h700, 50);
      close_pass(1, 31, 'h600, 51);
      chk(cap_tag[0] == 11, "R2 nearest kept", cap_tag[0], 11);
      chk(cap_tag[2] == 20 && cap_depth[2] == 'h10, "R1 truncated tie keeps first", cap_tag[2], 20);
      chk(cap_tag[4] == 40, "R2 equal depth keeps first", cap_tag[4], 40);
      chk(cap_tag[31] == 51, "R7 fragment with pass_end counted", cap_tag[31], 51);
      chk(!cap_hit[5] && cap_tag[5] == 'h0ABC_DEF0, "R5 empty pixel background", cap_tag[5], 'h0ABC_DEF0);

      feedback(32'h8000_0025);  // pixels 0, 2, 5, 31
      send(0, 'h300, 60); send(0, 'h200, 61); send(0, 'h900, 62); send(0, 'h350, 63);
      send(3, 'h100, 70); send(5, 'h100, 71);
      send(31, 'h600, 72);
      close_pass(0, 0, 0, 0);
      chk(cap_tag[0] == 63, "R3 nearest beyond reference", cap_tag[0], 63);
      chk(!cap_hit[3] && cap_tag[3] == 30 && cap_depth[3] == 'h80, "R8 frozen pixel keeps state", cap_tag[3], 30);
      chk(!cap_hit[5], "R8 unhit pixel frozen", cap_hit[5], 0);
      chk(!cap_hit[31], "R3 equal to reference rejected", cap_hit[31], 0);
      chk(!cap_hit[2] && cap_depth[2] == 'h7FF_FFFF, "R5 far reset depth", cap_depth[2], 'h7FF_FFFF);

      feedback(32'hFFFF_FFFF);
      chk(done == 0, "R9 one pixel still active", done, 0);
      close_pass(0, 0, 0, 0);
      feedback(32'hFFFF_FFFF);
      chk(done == 1, "R9 all peeled", done, 1);

      // tile 2: back-to-front with a new background
      load_bg(32'h0123_4567);
      start_tile(1);
      send(1, 'h300, 80); send(1, 'h500, 81); send(1, 'h400, 82);
      send(6, 'h200, 83);
      close_pass(0, 0, 0, 0);
      chk(cap_tag[1] == 81, "R4 farthest kept", cap_tag[1], 81);
      chk(cap_hit[1] == 1, "R11 mode latched at tile start", cap_hit[1], 1);
      chk(cap_tag[7] == 'h0123_4567 && cap_depth[7] == 0, "R12 new background tag", cap_tag[7], 'h0123_4567);

      feedback(32'h0000_0042);  // pixels 1 and 6
      send(1, 'h500, 90); send(1, 'h600, 91); send(1, 'h100, 92); send(1, 'h450, 93);
      send(6, 'h250, 94);
      close_pass(0, 0, 0, 0);
      chk(cap_tag[1] == 93, "R4 farthest in front of reference", cap_tag[1], 93);
      chk(!cap_hit[6] && cap_tag[6] == 'h0123_4567, "R4 behind reference rejected", cap_tag[6], 'h0123_4567);
      feedback(32'h0);
      chk(done == 1, "R9 empty feedback", done, 1);

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule